// File: doc/BRIEF.md
# Serial Audio Source and Master Clock Selector

This block sits at the front of an audio processing path. Three serial audio input groups arrive, each made of a data line, a frame (left/right) clock and a bit clock, along with three master clock inputs. A group-select field picks which audio group feeds the chip. A separate field picks the master clock source, so the two choices do not depend on each other. The selected audio group can be mirrored onto three pass-through pins so that other devices can share it. When mirroring is off, those pins sit at logic 0.

The master clock output has four modes: off, a copy of the selected master clock, a clock at 256 times the sample rate, or a clock at 512 times the sample rate. A separate bit tells the block whether the incoming master clock runs at 256x or 512x the sample rate. If 256x is requested from a 512x input, a toggle flop halves the clock. If 512x is requested from a 256x input, the block cannot produce that rate. It passes the input through instead and raises an unsupported-rate flag.

The output-mode logic is a four-state machine clocked by the selected master clock. The states are `MO_OFF`, `MO_COPY`, `MO_HALF` and `MO_FALLBACK`. On every rising edge of the selected master clock, the state moves to whichever state the current mode code and input-rate bit decode to:
- mode 00 goes to `MO_OFF`;
- mode 11 goes to `MO_COPY`;
- mode 01 goes to `MO_HALF` for a 512x input, or to `MO_COPY` for a 256x input;
- mode 10 goes to `MO_COPY` for a 512x input, or to `MO_FALLBACK` for a 256x input.

Any state can move to any other state in one edge. Asynchronous reset forces `MO_OFF`.

Top module: `srcclk_selector`

## Requirements
- R1: With `thru_en`=1, `grp_sel` codes 00, 01 and 10 route audio group 0, 1 and 2 to `lrclk_thru`, `bclk_thru` and `sdata_thru`. Group g consists of `lrclk_in[g]`, `bclk_in[g]` and `sdata_in[g]`.
- R2: `grp_sel` code 11 routes audio group 0.
- R3: With `thru_en`=0, the three pass-through outputs are 0 whatever the inputs do.
- R4: `mclk_sel` codes 00, 01 and 10 select `mclk_in[0]`, `[1]` and `[2]` as the master clock source. Code 11 selects `mclk_in[0]`.
- R5: Mode code 00 on `mclk_mode` holds `mclk_out` at 0.
- R6: Mode code 11 makes `mclk_out` a copy of the selected master clock.
- R7: Mode code 01 with `mclk_in_256`=0 makes `mclk_out` toggle once per rising edge of the selected master clock, which gives half its rate. Mode 01 with `mclk_in_256`=1 gives a copy of the selected master clock.
- R8: Mode code 10 with `mclk_in_256`=0 gives a copy of the selected master clock and keeps `rate_unsupported`=0. Mode 10 with `mclk_in_256`=1 also gives a copy, but raises `rate_unsupported`=1. In every other mode the flag is 0.
- R9: While `rst_n`=0, `mclk_out`=0 and `rate_unsupported`=0. After reset, a mode change takes effect at the next rising edge of the selected master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_in | input | 3 | Serial data line of each audio group |
| lrclk_in | input | 3 | Frame clock of each audio group |
| bclk_in | input | 3 | Bit clock of each audio group |
| mclk_in | input | 3 | Master clock candidates |
| grp_sel | input | 2 | Audio group select code |
| thru_en | input | 1 | Pass-through output enable |
| mclk_sel | input | 2 | Master clock select code |
| mclk_in_256 | input | 1 | Input master clock rate: 0 = 512x, 1 = 256x |
| mclk_mode | input | 2 | Output mode: 00 off, 01 256x, 10 512x, 11 copy |
| sdata_thru | output | 1 | Mirrored data line |
| lrclk_thru | output | 1 | Mirrored frame clock |
| bclk_thru | output | 1 | Mirrored bit clock |
| mclk_out | output | 1 | Master clock output |
| rate_unsupported | output | 1 | 512x requested from a 256x input |

## Verification
The assertions watch these properties on every rising edge of the selected master clock:
- exactly one source is chosen in each selector;
- the pass-through pins stay quiet while disabled;
- the output stays low while off;
- the divider alternates on every edge in half-rate mode;
- the fallback state is only ever entered after a 512x-from-256x request.

Only the bench's scenarios can show the actual routing of each group and clock, the rate of `mclk_out` (measured as edge counts over a fixed window for each mode, input rate and source) and the reset values.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;

    typedef enum logic [1:0] {
        MO_OFF      = 2'd0,
        MO_COPY     = 2'd1,
        MO_HALF     = 2'd2,
        MO_FALLBACK = 2'd3
    } mclk_state_e;

    localparam logic [1:0] MODE_CODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_CODE_256  = 2'b01;
    localparam logic [1:0] MODE_CODE_512  = 2'b10;
    localparam logic [1:0] MODE_CODE_COPY = 2'b11;

endpackage

// File: rtl/srcsel_mux.sv
module srcsel_mux #(
    parameter int N_SRC = 3,
    parameter int W     = 1,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC*W-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic [W-1:0]       y
);

    logic [N_SRC-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_hit
            if (gi == 0) begin : g_first
                // out-of-range codes fall back to source 0
                assign hit[gi] = (sel == SEL_W'(0)) || (32'(sel) >= N_SRC);
            end else begin : g_other
                assign hit[gi] = (sel == SEL_W'(gi));
            end
        end
    endgenerate

    always_comb begin
        y = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (hit[i]) y = y | src[i*W +: W];
        end
        if (!en) y = '0;
    end

    always_comb begin
        if (!$isunknown(sel)) begin
            assert_one_source_R1: assert ($onehot(hit))
                else $error("selector decoded %b", hit);
        end
    end

endmodule

// File: rtl/srcsel_mclk_gen.sv
module srcsel_mclk_gen
    import srcsel_pkg::*;
(
    input  logic       mclk_src,
    input  logic       rst_n,
    input  logic       in_256,
    input  logic [1:0] out_mode,
    output logic       mclk_out,
    output logic       rate_flag
);

    mclk_state_e state_q, state_d;
    logic        div_q;

    always_comb begin
        unique case (out_mode)
            MODE_CODE_OFF:  state_d = MO_OFF;
            MODE_CODE_256:  state_d = in_256 ? MO_COPY : MO_HALF;
            MODE_CODE_512:  state_d = in_256 ? MO_FALLBACK : MO_COPY;
            MODE_CODE_COPY: state_d = MO_COPY;
            default:        state_d = MO_OFF;
        endcase
    end

    always_ff @(posedge mclk_src or negedge rst_n) begin
        if (!rst_n) state_q <= MO_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge mclk_src or negedge rst_n) begin
        if (!rst_n)                 div_q <= 1'b0;
        else if (state_q == MO_HALF) div_q <= ~div_q;
        else                        div_q <= 1'b0;
    end

    always_comb begin
        unique case (state_q)
            MO_OFF:      mclk_out = 1'b0;
            MO_COPY:     mclk_out = mclk_src;
            MO_HALF:     mclk_out = div_q;
            MO_FALLBACK: mclk_out = mclk_src;
            default:     mclk_out = 1'b0;
        endcase
        rate_flag = (state_q == MO_FALLBACK);
    end

    assert_half_toggles_R7: assert property (@(posedge mclk_src) disable iff (!rst_n)
        (state_q == MO_HALF && $past(state_q == MO_HALF)) |-> (div_q != $past(div_q)))
        else $error("divider stalled in half-rate state");

    assert_fallback_cause_R8: assert property (@(posedge mclk_src) disable iff (!rst_n)
        (state_q == MO_FALLBACK) |-> $past(in_256 && out_mode == MODE_CODE_512))
        else $error("fallback state without 512x-from-256x request");

endmodule

// File: rtl/srcclk_selector.sv
module srcclk_selector #(
    parameter int N_GROUPS = 3,
    parameter int N_MCLK   = 3,
    localparam int GRP_W   = 3,
    localparam int GSEL_W  = $clog2(N_GROUPS),
    localparam int MSEL_W  = $clog2(N_MCLK)
) (
    input  logic                rst_n,
    input  logic [N_GROUPS-1:0] sdata_in,
    input  logic [N_GROUPS-1:0] lrclk_in,
    input  logic [N_GROUPS-1:0] bclk_in,
    input  logic [N_MCLK-1:0]   mclk_in,
    input  logic [GSEL_W-1:0]   grp_sel,
    input  logic                thru_en,
    input  logic [MSEL_W-1:0]   mclk_sel,
    input  logic                mclk_in_256,
    input  logic [1:0]          mclk_mode,
    output logic                sdata_thru,
    output logic                lrclk_thru,
    output logic                bclk_thru,
    output logic                mclk_out,
    output logic                rate_unsupported
);

    logic [N_GROUPS*GRP_W-1:0] grp_bus;
    logic [GRP_W-1:0]          grp_y;
    logic                      mclk_src;

    genvar gg;
    generate
        for (gg = 0; gg < N_GROUPS; gg++) begin : g_pack
            assign grp_bus[gg*GRP_W +: GRP_W] = {lrclk_in[gg], bclk_in[gg], sdata_in[gg]};
        end
    endgenerate

    srcsel_mux #(.N_SRC(N_GROUPS), .W(GRP_W)) u_grp_mux (
        .src (grp_bus),
        .sel (grp_sel),
        .en  (thru_en),
        .y   (grp_y)
    );

    assign {lrclk_thru, bclk_thru, sdata_thru} = grp_y;

    srcsel_mux #(.N_SRC(N_MCLK), .W(1)) u_mclk_mux (
        .src (mclk_in),
        .sel (mclk_sel),
        .en  (1'b1),
        .y   (mclk_src)
    );

    srcsel_mclk_gen u_mclk_gen (
        .mclk_src  (mclk_src),
        .rst_n     (rst_n),
        .in_256    (mclk_in_256),
        .out_mode  (mclk_mode),
        .mclk_out  (mclk_out),
        .rate_flag (rate_unsupported)
    );

    assert_thru_quiet_R3: assert property (@(posedge mclk_src) disable iff (!rst_n)
        !thru_en |-> ({lrclk_thru, bclk_thru, sdata_thru} == 3'b000))
        else $error("pass-through active while disabled");

    assert_off_quiet_R5: assert property (@(posedge mclk_src) disable iff (!rst_n)
        (mclk_mode == 2'b00 && $past(mclk_mode == 2'b00)) |-> !mclk_out)
        else $error("master clock output active while off");

endmodule

// File: tb/test_srcclk_selector.sv
module test_srcclk_selector;

    logic       clk = 1'b0;
    logic       m1 = 1'b0;
    logic       m2 = 1'b0;
    logic       rst_n;
    logic [2:0] sdata_in, lrclk_in, bclk_in;
    logic [1:0] grp_sel, mclk_sel, mclk_mode;
    logic       thru_en, mclk_in_256;
    logic       sdata_thru, lrclk_thru, bclk_thru, mclk_out, rate_unsupported;

    int n_tests = 0;
    int n_fail  = 0;
    int edges   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) begin
        m1 <= ~m1;
        m2 <= m2 ^ m1;
    end
    always @(posedge mclk_out) edges++;

    srcclk_selector i_srcclk_selector (
        .rst_n            (rst_n),
        .sdata_in         (sdata_in),
        .lrclk_in         (lrclk_in),
        .bclk_in          (bclk_in),
        .mclk_in          ({m2, m1, clk}),
        .grp_sel          (grp_sel),
        .thru_en          (thru_en),
        .mclk_sel         (mclk_sel),
        .mclk_in_256      (mclk_in_256),
        .mclk_mode        (mclk_mode),
        .sdata_thru       (sdata_thru),
        .lrclk_thru       (lrclk_thru),
        .bclk_thru        (bclk_thru),
        .mclk_out         (mclk_out),
        .rate_unsupported (rate_unsupported)
    );

    // {thru_en, grp_sel[1:0], pattern[8:0], expected {lr,bclk,data}}
    localparam logic [8:0] PAT_A = 9'b101_011_110;
    localparam logic [8:0] PAT_B = 9'b010_100_001;
    localparam logic [14:0] VECS [8] = '{
        {1'b1, 2'b00, PAT_A, 3'b110},
        {1'b1, 2'b01, PAT_A, 3'b011},
        {1'b1, 2'b10, PAT_A, 3'b101},
        {1'b1, 2'b11, PAT_A, 3'b110},
        {1'b0, 2'b01, PAT_A, 3'b000},
        {1'b1, 2'b10, PAT_B, 3'b010},
        {1'b1, 2'b00, PAT_B, 3'b001},
        {1'b0, 2'b10, PAT_B, 3'b000}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(input logic [1:0] sel, input logic in256, input logic [1:0] mode,
                           input int exp_edges, input int exp_flag, input string tag);
        @(negedge clk);
        mclk_sel = sel; mclk_in_256 = in256; mclk_mode = mode;
        repeat (8) @(negedge clk);
        edges = 0;
        repeat (64) @(negedge clk);
        check({tag, " edges"}, edges, exp_edges);
        check({tag, " flag"}, int'(rate_unsupported), exp_flag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sdata_in = '0; lrclk_in = '0; bclk_in = '0;
        grp_sel = '0; thru_en = 1'b0; mclk_sel = '0;
        mclk_in_256 = 1'b0; mclk_mode = 2'b11;
        repeat (4) @(negedge clk);
        check("R9 reset mclk_out", int'(mclk_out), 0);
        check("R9 reset flag", int'(rate_unsupported), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mclk_mode = 2'b00;

        for (int v = 0; v < 8; v++) begin
            logic [14:0] e;
            string tag;
            e = VECS[v];
            @(negedge clk);
            thru_en = e[14];
            grp_sel = e[13:12];
            for (int g = 0; g < 3; g++) begin
                lrclk_in[g] = e[3 + 3*g + 2];
                bclk_in[g]  = e[3 + 3*g + 1];
                sdata_in[g] = e[3 + 3*g];
            end
            #2;
            tag = !e[14] ? "R3 thru off" : (e[13:12] == 2'b11 ? "R2 group code 11" : "R1 group route");
            check(tag, int'({lrclk_thru, bclk_thru, sdata_thru}), int'(e[2:0]));
        end

        measure(2'b00, 1'b0, 2'b00, 0,  0, "R5 off");
        measure(2'b00, 1'b0, 2'b11, 64, 0, "R6 copy");
        measure(2'b00, 1'b0, 2'b01, 32, 0, "R7 halve 512x input");
        measure(2'b00, 1'b1, 2'b01, 64, 0, "R7 256x from 256x");
        measure(2'b00, 1'b0, 2'b10, 64, 0, "R8 512x from 512x");
        measure(2'b00, 1'b1, 2'b10, 64, 1, "R8 fallback");
        measure(2'b01, 1'b0, 2'b11, 32, 0, "R4 source 1");
        measure(2'b10, 1'b0, 2'b11, 16, 0, "R4 source 2");
        measure(2'b11, 1'b0, 2'b11, 64, 0, "R4 code 11");
        measure(2'b10, 1'b0, 2'b01, 8,  0, "R7 halve source 2");
        measure(2'b01, 1'b1, 2'b10, 32, 1, "R8 fallback source 1");

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async reset mclk_out", int'(mclk_out), 0);
        check("R9 async reset flag", int'(rate_unsupported), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule